// File: doc/BRIEF.md
# ATA PIO Strobe Timing Generator

This block produces the active-low read/write strobe for programmed-I/O and multiword DMA data cycles, and for task-file register cycles, on a parallel ATA bus. A single 32-bit timing word sets every phase length. Each count field uses value-plus-one encoding, so a field of zero gives one clock.

A controller selects the cycle with three inputs: read or write, data or command, and whether this is the first cycle of a burst. It then pulses `start`. The block runs an optional setup phase, then the strobe-active phase, then the strobe-inactive (recovery) phase. It ends with a one-clock `done` pulse. `busy` covers the whole cycle, and the bus-drive enable follows `busy` on writes.

The timing word is captured when the cycle is accepted. A start that arrives while a cycle is in progress is dropped. Data cycles are refused while the Ultra DMA enable bit is set.

Top module: `ata_pio_strobe_gen`

## Requirements
- R1: During and immediately after reset, the outputs are idle: `strobe_n`=1, `busy`=0, `drive_en`=0 and `done`=0.
- R2: In a data cycle the strobe is low for word[8:4]+1 clocks and then high for word[3:0]+1 clocks of recovery.
- R3: In a command (task-file) cycle the strobe is low for word[17:13]+1 clocks and then high for word[12:9]+1 clocks of recovery.
- R4: When `first_cycle` is 1, a setup phase with the strobe high comes before the active phase. It lasts word[24:22]+1 clocks for data cycles and word[27:25]+1 clocks for command cycles. When `first_cycle` is 0 there is no setup phase.
- R5: `busy` rises in the clock after the edge that accepts `start`, stays high through every phase, and falls together with a `done` pulse that is exactly one clock long.
- R6: A `start` pulse that arrives while `busy` is high is ignored, and the current cycle keeps its phase lengths.
- R7: The timing word and the select inputs are sampled when the cycle is accepted, so a change during the cycle has no effect on it.
- R8: When word bit 28 (Ultra DMA enable) is 1, a data-cycle start is ignored and `busy` stays low. Command cycles still run.
- R9: `drive_en` equals `busy` for write cycles and stays 0 for read cycles.
- R10: The strobe goes low only while `busy` is high, and only once in each cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Cycle request pulse |
| is_write | input | 1 | 1 = write cycle, 0 = read cycle |
| is_cmd | input | 1 | 1 = task-file register cycle, 0 = data cycle |
| first_cycle | input | 1 | 1 = first cycle of a burst, which adds the setup phase |
| timing_word | input | 32 | Packed phase counts and enables |
| strobe_n | output | 1 | Active-low read/write strobe |
| drive_en | output | 1 | Host drives the data bus |
| busy | output | 1 | Cycle in progress |
| done | output | 1 | One-clock end-of-cycle pulse |

## Verification
The checker monitors, on every cycle, the relationship between `strobe_n`, `drive_en`, `busy` and `done`. It confirms that the strobe and the drive enable are confined to `busy`, that `busy` only falls with a `done` pulse, and that `done` lasts one clock. Phase lengths, the field-to-phase mapping, the setup choice and the cases where a start is refused need a known timing word and request. These can only be shown by the bench scenarios: its model predicts every output clock by clock, and it compares the prediction during idle stretches as well.

// File: rtl/ata_strobe_pkg.sv
package ata_strobe_pkg;

    localparam int CNT_W = 5;

    // Field positions in the timing word (the bus behaviour depends on them)
    localparam int DREC_LSB  = 0;   localparam int DREC_W  = 4;
    localparam int DACT_LSB  = 4;   localparam int DACT_W  = 5;
    localparam int CREC_LSB  = 9;   localparam int CREC_W  = 4;
    localparam int CACT_LSB  = 13;  localparam int CACT_W  = 5;
    localparam int DSET_LSB  = 22;  localparam int DSET_W  = 3;
    localparam int CSET_LSB  = 25;  localparam int CSET_W  = 3;
    localparam int UDMA_BIT  = 28;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_ACTIVE,
        PH_RECOVER
    } phase_e;

    typedef struct packed {
        logic             run_setup;
        logic [CNT_W-1:0] setup_cnt;
        logic [CNT_W-1:0] active_cnt;
        logic [CNT_W-1:0] recover_cnt;
    } cycle_plan_t;

    function automatic logic [CNT_W-1:0] field(input logic [31:0] w, input int lsb, input int width);
        logic [CNT_W-1:0] r;
        r = '0;
        for (int i = 0; i < CNT_W; i++) begin
            if (i < width) r[i] = w[lsb + i];
        end
        return r;
    endfunction

endpackage

// File: rtl/strobe_plan_decode.sv
module strobe_plan_decode
    import ata_strobe_pkg::*;
(
    input  logic [31:0]  word,
    input  logic         is_cmd,
    input  logic         first_cycle,
    output cycle_plan_t  plan,
    output logic         udma_block
);
    always_comb begin
        plan.run_setup = first_cycle;
        if (is_cmd) begin
            plan.setup_cnt   = field(word, CSET_LSB, CSET_W);
            plan.active_cnt  = field(word, CACT_LSB, CACT_W);
            plan.recover_cnt = field(word, CREC_LSB, CREC_W);
        end else begin
            plan.setup_cnt   = field(word, DSET_LSB, DSET_W);
            plan.active_cnt  = field(word, DACT_LSB, DACT_W);
            plan.recover_cnt = field(word, DREC_LSB, DREC_W);
        end
        udma_block = word[UDMA_BIT] && !is_cmd;
    end
endmodule

// File: rtl/strobe_phase_seq.sv
module strobe_phase_seq
    import ata_strobe_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        accept,
    input  cycle_plan_t plan_in,
    input  logic        is_write,
    output phase_e      phase,
    output logic        write_q,
    output logic        done
);
    cycle_plan_t      plan_q;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            cnt     <= '0;
            plan_q  <= '0;
            write_q <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    if (accept) begin
                        plan_q  <= plan_in;
                        write_q <= is_write;
                        if (plan_in.run_setup) begin
                            phase <= PH_SETUP;
                            cnt   <= plan_in.setup_cnt;
                        end else begin
                            phase <= PH_ACTIVE;
                            cnt   <= plan_in.active_cnt;
                        end
                    end
                end
                PH_SETUP: begin
                    if (cnt == '0) begin
                        phase <= PH_ACTIVE;
                        cnt   <= plan_q.active_cnt;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_ACTIVE: begin
                    if (cnt == '0) begin
                        phase <= PH_RECOVER;
                        cnt   <= plan_q.recover_cnt;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: begin
                    if (cnt == '0) begin
                        phase   <= PH_IDLE;
                        write_q <= 1'b0;
                        done    <= 1'b1;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/ata_pio_strobe_gen.sv
module ata_pio_strobe_gen
    import ata_strobe_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        is_write,
    input  logic        is_cmd,
    input  logic        first_cycle,
    input  logic [31:0] timing_word,
    output logic        strobe_n,
    output logic        drive_en,
    output logic        busy,
    output logic        done
);
    cycle_plan_t plan;
    logic        udma_block;
    logic        accept;
    phase_e      phase;
    logic        write_q;

    strobe_plan_decode u_dec (
        .word        (timing_word),
        .is_cmd      (is_cmd),
        .first_cycle (first_cycle),
        .plan        (plan),
        .udma_block  (udma_block)
    );

    assign accept = start && (phase == PH_IDLE) && !udma_block;

    strobe_phase_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .accept   (accept),
        .plan_in  (plan),
        .is_write (is_write),
        .phase    (phase),
        .write_q  (write_q),
        .done     (done)
    );

    assign busy     = (phase != PH_IDLE);
    assign strobe_n = (phase != PH_ACTIVE);
    assign drive_en = busy && write_q;
endmodule

// File: rtl/strobe_gen_checker.sv
module strobe_gen_checker (
    input logic clk,
    input logic rst,
    input logic strobe_n,
    input logic drive_en,
    input logic busy,
    input logic done
);
    a_r10_strobe_in_busy: assert property (@(posedge clk) disable iff (rst)
        !strobe_n |-> busy);

    a_r9_drive_in_busy: assert property (@(posedge clk) disable iff (rst)
        drive_en |-> busy);

    a_r5_fall_with_done: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    a_r5_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r5_done_after_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(busy) && !busy));

    a_r10_recover_before_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(strobe_n));
endmodule

bind ata_pio_strobe_gen strobe_gen_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .strobe_n (strobe_n),
    .drive_en (drive_en),
    .busy     (busy),
    .done     (done)
);

// File: tb/ata_pio_strobe_gen_bench.sv
module ata_pio_strobe_gen_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        is_write = 1'b0;
    logic        is_cmd = 1'b0;
    logic        first_cycle = 1'b0;
    logic [31:0] timing_word = '0;
    logic        strobe_n, drive_en, busy, done;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit run_cmp = 1'b0;
    string idle_tag = "R1";

    typedef struct {
        logic  s_n;
        logic  bsy;
        logic  drv;
        logic  dn;
        string tag;
    } exp_t;

    exp_t expq[$];

    always #5 clk = ~clk;

    ata_pio_strobe_gen u_ata_pio_strobe_gen (
        .clk(clk), .rst(rst), .start(start), .is_write(is_write),
        .is_cmd(is_cmd), .first_cycle(first_cycle), .timing_word(timing_word),
        .strobe_n(strobe_n), .drive_en(drive_en), .busy(busy), .done(done)
    );

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    task automatic check4(string tag, logic s, logic b, logic d, logic dn);
        checks++;
        if (strobe_n !== s || busy !== b || drive_en !== d || done !== dn) begin
            failures++;
            $display("FAIL %s t=%0t actual strobe_n=%b busy=%b drive_en=%b done=%b expected %b %b %b %b",
                     tag, $time, strobe_n, busy, drive_en, done, s, b, d, dn);
        end
    endtask

    // Clock-by-clock comparison, 2 ns after each rising edge
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            failures++;
            $display("FAIL watchdog expired");
            finish_run();
        end
        #2;
        if (run_cmp) begin
            if (expq.size() > 0) begin
                exp_t e;
                e = expq.pop_front();
                check4(e.tag, e.s_n, e.bsy, e.drv, e.dn);
            end else begin
                check4(idle_tag, 1'b1, 1'b0, 1'b0, 1'b0);
            end
        end
    end

    function automatic logic [31:0] mk(int drec, int dact, int crec, int cact,
                                       int dset, int cset, bit udma);
        logic [31:0] w;
        w = '0;
        w[3:0]   = drec[3:0];
        w[8:4]   = dact[4:0];
        w[12:9]  = crec[3:0];
        w[17:13] = cact[4:0];
        w[24:22] = dset[2:0];
        w[27:25] = cset[2:0];
        w[28]    = udma;
        w[29]    = 1'b1;
        return w;
    endfunction

    task automatic push_n(int n, logic s, logic b, logic d, logic dn, string tag);
        for (int i = 0; i < n; i++) begin
            exp_t e;
            e.s_n = s; e.bsy = b; e.drv = d; e.dn = dn; e.tag = tag;
            expq.push_back(e);
        end
    endtask

    // Model: phase lengths taken from the requirements' field positions
    task automatic model(string tag, logic [31:0] w, bit wr, bit cmd, bit first);
        int setup, act, rec;
        if (w[28] && !cmd) return;
        setup = cmd ? int'(w[27:25]) : int'(w[24:22]);
        act   = cmd ? int'(w[17:13]) : int'(w[8:4]);
        rec   = cmd ? int'(w[12:9])  : int'(w[3:0]);
        if (first) push_n(setup + 1, 1'b1, 1'b1, wr, 1'b0, tag);
        push_n(act + 1, 1'b0, 1'b1, wr, 1'b0, tag);
        push_n(rec + 1, 1'b1, 1'b1, wr, 1'b0, tag);
        push_n(1, 1'b1, 1'b0, 1'b0, 1'b1, tag);
    endtask

    task automatic run(string tag, logic [31:0] w, bit wr, bit cmd, bit first,
                       int change_at, bit poke_start, logic [31:0] alt,
                       bit alt_wr, bit alt_cmd, bit alt_first);
        int n;
        @(negedge clk);
        idle_tag = tag;
        timing_word = w; is_write = wr; is_cmd = cmd; first_cycle = first;
        start = 1'b1;
        model(tag, w, wr, cmd, first);
        n = 0;
        forever begin
            @(negedge clk);
            n++;
            start = 1'b0;
            if (n == change_at) begin
                timing_word = alt; is_write = alt_wr; is_cmd = alt_cmd;
                first_cycle = alt_first;
                start = poke_start;
            end
            if (n > change_at + 1 && expq.size() == 0) break;
        end
        // leave a few idle clocks compared against the idle state
        repeat (2) @(negedge clk);
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check4("R1", 1'b1, 1'b0, 1'b0, 1'b0);
        start = 1'b1;
        @(negedge clk);
        check4("R1", 1'b1, 1'b0, 1'b0, 1'b0);
        start = 1'b0;
        rst = 1'b0;
        run_cmp = 1'b1;
        repeat (2) @(negedge clk);

        // R2: data read, no setup
        run("R2", mk(2, 3, 0, 0, 5, 0, 0), 0, 0, 0, 0, 0, '0, 0, 0, 0);
        // R4 / R9: data write, first cycle with setup
        run("R4", mk(1, 2, 7, 7, 4, 6, 0), 1, 0, 1, 0, 0, '0, 0, 0, 0);
        // R3: command read, first cycle with command setup
        run("R3", mk(9, 9, 5, 17, 7, 2, 0), 0, 1, 1, 0, 0, '0, 0, 0, 0);
        // R2: all-zero fields, one clock per phase, with setup
        run("R2", mk(0, 0, 0, 0, 0, 0, 0), 0, 0, 1, 0, 0, '0, 0, 0, 0);
        // R9: maximum data fields, write
        run("R9", mk(15, 31, 0, 0, 7, 0, 0), 1, 0, 1, 0, 0, '0, 0, 0, 0);
        // R3: maximum command fields, write, no setup
        run("R3", mk(0, 0, 15, 31, 0, 7, 0), 1, 1, 0, 0, 0, '0, 0, 0, 0);
        // R6: a start during busy is ignored
        run("R6", mk(4, 6, 0, 0, 0, 0, 0), 0, 0, 0, 3, 1,
            mk(0, 0, 0, 0, 0, 0, 0), 1, 1, 1);
        // R7: timing word and selects changed mid-cycle without a start
        run("R7", mk(5, 7, 0, 0, 3, 0, 0), 1, 0, 1, 2, 0,
            mk(1, 1, 1, 1, 1, 1, 0), 0, 1, 0);
        // R8: Ultra DMA enable refuses data cycles
        run("R8", mk(3, 3, 3, 3, 3, 3, 1), 1, 0, 1, 0, 0, '0, 0, 0, 0);
        // R8: command cycles still run with Ultra DMA enable set
        run("R8", mk(3, 3, 2, 4, 3, 1, 1), 0, 1, 1, 0, 0, '0, 0, 0, 0);
        // R5 / R10: back-to-back minimum data cycles
        run("R5", mk(0, 0, 0, 0, 0, 0, 0), 1, 0, 0, 0, 0, '0, 0, 0, 0);
        run("R10", mk(0, 1, 0, 0, 0, 0, 0), 0, 0, 0, 0, 0, '0, 0, 0, 0);

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule